// File: doc/BRIEF.md
# External Bus Handover Controller

This block decides when the chip lets an outside master take over the external memory bus. The outside device asks for the bus on an active-low request line. The block weighs that request against the access requests of the core and the on-chip DMA masters, and the outside device always ranks last. When the bus is free, the block first floats its address, data, strobe and select drivers and only then raises the grant. While the bus is lent out, any internal master that wants an external access is held off. The block reports that with a hang flag, and with a stall when the waiting master is the core.

The memory interface tells the block when each external access starts and ends, and tags each start with what the instruction does next. The grant is decided only between accesses. It is never issued in the gap between the two reads of one instruction. In the gap between a read and the write of the same instruction it is issued, unless the exclusive mode bit is set. A separate boot reset holds the internal masters quiet. The handover logic keeps running while that reset is high, so an outside device can take the bus during boot.

Top module: `xbus_handover_ctl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `bus_grant`=0, `pad_oe`=1, `grant_hang`=0 and `core_stall`=0.
- R2: `bus_req_n` passes through two synchronizer flops. On an idle bus, if `bus_req_n` is low at a rising edge and stays low, `bus_grant` is 0 after that edge and the next two, and is 1 after the fourth edge.
- R3: The handover never starts while any of these holds: an internal request is pending, an access is in progress, or an access starts in that cycle. The external request has the lowest priority.
- R4: `pad_oe` goes to 0 one clock before `bus_grant` rises, and it stays 0 for as long as `bus_grant` is 1.
- R5: `core_stall` is 1 exactly when `int_req[0]` (the core) is high, `boot_rst` is low and the bus is not owned (`pad_oe`=0).
- R6: An access started with `acc_tag`=2'b01 (first of two reads) blocks the handover until the next access has started and then completed. `acc_tag`=2'b00 (single) and 2'b10 (read followed by write) allow the handover once the access completes.
- R7: After `bus_req_n` returns high, `bus_grant` falls on the third edge. On that edge `pad_oe` is still 0, and `pad_oe` returns to 1 one edge later.
- R8: `grant_hang` is 1 exactly when some unmasked `int_req` bit is high and the bus is not owned.
- R9: While `boot_rst` is high, every `int_req` bit is ignored (no blocking, no stall, no hang). The external request is still granted with the R2 latency.
- R10: With `excl_mode`=1 sampled at an access start, `acc_tag`=2'b10 locks the bus the same way as 2'b01.
- R11: If the synchronized request drops during the float cycle, the block returns to owning the bus on the next edge without raising `bus_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| boot_rst | input | 1 | Boot/core reset; masks internal requests only |
| excl_mode | input | 1 | Core exclusive mode: read-then-write also locks |
| bus_req_n | input | 1 | External bus request, active low, asynchronous |
| int_req | input | N_MASTERS | Internal external-access requests, bit 0 is the core |
| acc_start | input | 1 | An external access starts this cycle |
| acc_tag | input | 2 | Tag of the starting access: 00 single, 01 read pair head, 10 read then write |
| acc_done | input | 1 | The current external access completes this cycle |
| bus_grant | output | 1 | Bus granted to the external master |
| grant_hang | output | 1 | An internal master is held off by the grant |
| pad_oe | output | 1 | Output enable for address, data, strobe and select drivers |
| core_stall | output | 1 | Stall to the core |

## Verification
The hazard of interest is a new internal request or an access start that lands in the same cycle as the synchronized external request first becomes visible to the decision. If it does, the block must stay owner in that cycle. The directed part sets up this collision with an access start and the request released together, and the model checks each cycle that the float stage does not begin. A long random phase stacks request toggles on top of access starts, completions and boot-reset changes, so both events often fall on the same edge. The outputs are compared on every clock with a reference kept in the bench.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

    typedef enum logic [1:0] {
        XS_OWN     = 2'd0,
        XS_FLOAT   = 2'd1,
        XS_LENT    = 2'd2,
        XS_RECLAIM = 2'd3
    } xbh_state_e;

    typedef enum logic [1:0] {
        TAG_SOLO    = 2'b00,
        TAG_RD_HEAD = 2'b01,
        TAG_RD_WR   = 2'b10
    } acc_tag_e;

    typedef struct packed {
        logic grant;
        logic oe;
        logic hang;
        logic stall;
    } xbh_out_t;

    function automatic xbh_out_t xbh_decode(xbh_state_e st, logic pend, logic core_pend);
        xbh_out_t o;
        o.grant = (st == XS_LENT);
        o.oe    = (st == XS_OWN);
        o.hang  = (st != XS_OWN) && pend;
        o.stall = (st != XS_OWN) && core_pend;
        return o;
    endfunction

    function automatic logic xbh_tag_locks(logic [1:0] tag, logic excl);
        return (tag == TAG_RD_HEAD) || (excl && (tag == TAG_RD_WR));
    endfunction

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xbh_atomic.sv
module xbh_atomic
    import xbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_start,
    input  logic [1:0] acc_tag,
    input  logic       acc_done,
    input  logic       excl_mode,
    output logic       busy,
    output logic       lock
);
    logic busy_q, lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (acc_start)     busy_q <= 1'b1;
            else if (acc_done) busy_q <= 1'b0;
            if (acc_start)     lock_q <= xbh_tag_locks(acc_tag, excl_mode);
        end
    end

    assign busy = busy_q;
    assign lock = lock_q;

    // R6: a pair lock survives until the next access starts
    assert_lock_until_next_R6: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !acc_start) |=> lock_q);

    // R6: a started access keeps the block busy until a completion
    assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !acc_done) |=> busy_q);
endmodule

// File: rtl/xbh_handover.sv
module xbh_handover
    import xbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_req,
    input  logic       block,
    output xbh_state_e state
);
    xbh_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XS_OWN:     if (ext_req && !block) st_d = XS_FLOAT;
            XS_FLOAT:   st_d = ext_req ? XS_LENT : XS_OWN;
            XS_LENT:    if (!ext_req) st_d = XS_RECLAIM;
            XS_RECLAIM: st_d = XS_OWN;
            default:    st_d = XS_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= XS_OWN;
        else     st_q <= st_d;
    end

    assign state = st_q;

    assert_hold_when_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_OWN && block) |=> (st_q == XS_OWN));

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_LENT && !ext_req) |=> (st_q == XS_RECLAIM));

    assert_abort_float_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_FLOAT && !ext_req) |=> (st_q == XS_OWN));
endmodule

// File: rtl/xbus_handover_ctl.sv
module xbus_handover_ctl
    import xbh_pkg::*;
#(
    parameter int N_MASTERS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 boot_rst,
    input  logic                 excl_mode,
    input  logic                 bus_req_n,
    input  logic [N_MASTERS-1:0] int_req,
    input  logic                 acc_start,
    input  logic [1:0]           acc_tag,
    input  logic                 acc_done,
    output logic                 bus_grant,
    output logic                 grant_hang,
    output logic                 pad_oe,
    output logic                 core_stall
);
    localparam int CORE_IDX = 0;

    logic                 ext_req_s;
    logic                 acc_busy, acc_lock;
    logic [N_MASTERS-1:0] live_req;
    logic                 int_pend, block;
    xbh_state_e           state;
    xbh_out_t             outs;

    xbh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (~bus_req_n),
        .q   (ext_req_s)
    );

    xbh_atomic u_atomic (
        .clk       (clk),
        .rst       (rst),
        .acc_start (acc_start),
        .acc_tag   (acc_tag),
        .acc_done  (acc_done),
        .excl_mode (excl_mode),
        .busy      (acc_busy),
        .lock      (acc_lock)
    );

    assign live_req = boot_rst ? '0 : int_req;
    assign int_pend = |live_req;
    assign block    = int_pend | acc_busy | acc_lock | acc_start;

    xbh_handover u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ext_req (ext_req_s),
        .block   (block),
        .state   (state)
    );

    assign outs       = xbh_decode(state, int_pend, live_req[CORE_IDX]);
    assign bus_grant  = outs.grant;
    assign pad_oe     = outs.oe;
    assign grant_hang = outs.hang;
    assign core_stall = outs.stall;

    assert_float_before_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_grant) |-> ($past(!pad_oe) && $past(!bus_grant)));

    assert_stall_only_lent_R5: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> !pad_oe);

    assert_hang_only_lent_R8: assert property (@(posedge clk) disable iff (rst)
        grant_hang |-> !pad_oe);

    assert_boot_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        boot_rst |-> (!core_stall && !grant_hang));
endmodule

// File: tb/xbus_handover_ctl_test.sv
module xbus_handover_ctl_test;
    localparam int NM = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, boot_rst, excl_mode, bus_req_n;
    logic [NM-1:0] int_req;
    logic          acc_start, acc_done;
    logic [1:0]    acc_tag;
    logic          bus_grant, grant_hang, pad_oe, core_stall;

    xbus_handover_ctl #(.N_MASTERS(NM), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .boot_rst(boot_rst), .excl_mode(excl_mode),
        .bus_req_n(bus_req_n), .int_req(int_req), .acc_start(acc_start),
        .acc_tag(acc_tag), .acc_done(acc_done), .bus_grant(bus_grant),
        .grant_hang(grant_hang), .pad_oe(pad_oe), .core_stall(core_stall)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    // reference state: 0 owned, 1 floating, 2 lent, 3 reclaiming
    bit m_q1, m_q2, m_busy, m_lock;
    int m_st;

    task automatic chk(string lbl, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", lbl, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit n_q1, n_q2, n_busy, n_lock, blk;
        int n_st;
        logic [NM-1:0] mk;
        mk = boot_rst ? '0 : int_req;
        if (rst) begin
            n_q1 = 0; n_q2 = 0; n_busy = 0; n_lock = 0; n_st = 0;
        end else begin
            blk    = (mk != 0) || m_busy || m_lock || acc_start;
            n_q1   = !bus_req_n;
            n_q2   = m_q1;
            n_busy = acc_start ? 1'b1 : (acc_done ? 1'b0 : m_busy);
            n_lock = acc_start ? ((acc_tag == 2'b01) || (excl_mode && acc_tag == 2'b10)) : m_lock;
            case (m_st)
                0:       n_st = (m_q2 && !blk) ? 1 : 0;
                1:       n_st = m_q2 ? 2 : 0;
                2:       n_st = m_q2 ? 2 : 3;
                default: n_st = 0;
            endcase
        end
        @(posedge clk);
        m_q1 = n_q1; m_q2 = n_q2; m_busy = n_busy; m_lock = n_lock; m_st = n_st;
        cyc++;
        #15;
        mk = boot_rst ? '0 : int_req;
        chk("R2 grant vs model", bus_grant, m_st == 2);
        chk("R4 pad_oe vs model", pad_oe, m_st == 0);
        chk("R8 hang vs model", grant_hang, (m_st != 0) && (mk != 0));
        chk("R5 stall vs model", core_stall, (m_st != 0) && mk[0]);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic release_bus();
        bus_req_n = 1'b1;
        ticks(4);
        chk("R7 owned again", pad_oe, 1'b1);
    endtask

    task automatic one_access(logic [1:0] tag);
        acc_start = 1'b1; acc_tag = tag; int_req = 4'b0001;
        tick();
        acc_start = 1'b0; int_req = '0; acc_done = 1'b1;
        tick();
        acc_done = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish (cycle %0d)", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1; boot_rst = 0; excl_mode = 0; bus_req_n = 1; int_req = '0;
        acc_start = 0; acc_tag = 2'b00; acc_done = 0;
        m_q1 = 0; m_q2 = 0; m_busy = 0; m_lock = 0; m_st = 0;
        ticks(3);
        chk("R1 grant in reset", bus_grant, 0);
        chk("R1 oe in reset", pad_oe, 1);
        chk("R1 hang in reset", grant_hang, 0);
        chk("R1 stall in reset", core_stall, 0);
        rst = 0;
        tick();
        chk("R1 grant after reset", bus_grant, 0);

        // R2 latency on idle bus, R4 float first
        bus_req_n = 0;
        ticks(2);
        chk("R2 no grant after two edges", bus_grant, 0);
        tick();
        chk("R4 floated before grant", pad_oe, 0);
        chk("R4 grant not yet", bus_grant, 0);
        tick();
        chk("R2 grant on fourth edge", bus_grant, 1);

        // R5 / R8 while lent
        int_req = 4'b0001; tick();
        chk("R5 core stalled", core_stall, 1);
        chk("R8 core hang", grant_hang, 1);
        int_req = 4'b0100; tick();
        chk("R5 no stall for DMA", core_stall, 0);
        chk("R8 DMA hang", grant_hang, 1);
        int_req = '0;

        // R7 release sequence
        bus_req_n = 1;
        ticks(2);
        chk("R7 grant held during sync", bus_grant, 1);
        tick();
        chk("R7 grant dropped", bus_grant, 0);
        chk("R7 drivers still off", pad_oe, 0);
        tick();
        chk("R7 drivers back", pad_oe, 1);

        // R3 lowest priority
        int_req = 4'b1000; bus_req_n = 0;
        ticks(8);
        chk("R3 no grant while DMA pending", bus_grant, 0);
        chk("R3 drivers kept", pad_oe, 1);
        int_req = '0; tick();
        chk("R3 float after request clears", pad_oe, 0);
        tick();
        chk("R3 grant after request clears", bus_grant, 1);
        release_bus();

        // R3 collision: access start on the cycle the request becomes visible
        bus_req_n = 0; ticks(2);
        acc_start = 1; acc_tag = 2'b00; tick();
        acc_start = 0; acc_done = 1;
        chk("R3 start blocks handover", pad_oe, 1);
        tick(); acc_done = 0;
        ticks(2);
        chk("R3 granted after access", bus_grant, 1);
        release_bus();

        // R6 read pair lock
        one_access(2'b01);
        bus_req_n = 0;
        ticks(8);
        chk("R6 no grant inside read pair", bus_grant, 0);
        one_access(2'b00);
        ticks(2);
        chk("R6 grant after pair", bus_grant, 1);
        release_bus();

        one_access(2'b10);
        bus_req_n = 0;
        ticks(4);
        chk("R6 grant between read and write", bus_grant, 1);
        release_bus();

        // R10 exclusive mode
        excl_mode = 1;
        one_access(2'b10);
        bus_req_n = 0;
        ticks(8);
        chk("R10 exclusive read-write locks", bus_grant, 0);
        one_access(2'b00);
        ticks(2);
        chk("R10 grant after exclusive sequence", bus_grant, 1);
        release_bus();
        excl_mode = 0;

        // R9 boot reset
        boot_rst = 1; int_req = 4'b1111; bus_req_n = 0;
        ticks(3);
        chk("R9 floated in boot", pad_oe, 0);
        tick();
        chk("R9 granted in boot", bus_grant, 1);
        chk("R9 no stall in boot", core_stall, 0);
        chk("R9 no hang in boot", grant_hang, 0);
        release_bus();
        boot_rst = 0; int_req = '0;

        // R11 request withdrawn during float
        bus_req_n = 0; tick();
        bus_req_n = 1; ticks(2);
        chk("R11 floated", pad_oe, 0);
        chk("R11 no grant", bus_grant, 0);
        tick();
        chk("R11 back to owner", pad_oe, 1);
        chk("R11 never granted", bus_grant, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 20 == 0) bus_req_n = ~bus_req_n;
            int_req   = ($urandom % 4 == 0) ? NM'($urandom) : '0;
            acc_start = ($urandom % 6 == 0);
            acc_tag   = 2'($urandom % 3);
            acc_done  = ($urandom % 3 == 0);
            if ($urandom % 40 == 0) excl_mode = ~excl_mode;
            if ($urandom % 60 == 0) boot_rst = ~boot_rst;
            rst = ($urandom % 700 == 0);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule